// File: doc/BRIEF.md
# Byte Write-and-Poll Controller for Self-Timed EEPROM

This block sits between a host request port and a parallel EEPROM that behaves like a static RAM on reads but finishes each byte write on an internal timer. A host request is either a read or a single-byte write. A write is sent as one write-enable pulse with the address and data set up before the pulse and held after it. The controller then waits until the memory reports that its internal write has finished, and only then takes the next request.

The wait uses one of two completion tests, chosen by the `POLL_MODE` parameter. In data-poll mode (0) the controller reads the location it just wrote, again and again. While the memory is busy it returns the inverse of the top data bit, so the write is complete once the top bit of the read-back matches the written byte. In ready/busy mode (1) the controller watches an open-drain status line that the memory pulls low while busy. The line has a pull-up, so several memories can share it. It passes through a flop synchronizer before it is used.

A write that stays busy past a cycle limit is ended with an error flag. All strobes are registered, and every timing width is a parameter in clock cycles. In ready/busy mode the sum `HOLD_CYC + POLL_GAP + RD_CYC` must be at least `SYNC_STAGES + 1`. This makes sure the busy level has passed the synchronizer before the first check.

Top module: `eewp_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: `req_ready` is 1 only while no request is in progress. A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from that edge until the response, and it is 1 again in the cycle after `rsp_valid`.
- R3: A write first drives the address and data with `mem_ce_n` low and `mem_oe_n` and `mem_we_n` high for `SETUP_CYC` cycles. Then `mem_we_n` is low for exactly `WE_CYC` cycles. Then the address and data stay driven with `mem_we_n` high for `HOLD_CYC` cycles.
- R4: `mem_oe_n` and `mem_we_n` are never low in the same cycle, and `mem_dq_oe` is 0 in every cycle where `mem_oe_n` is 0.
- R5: In data-poll mode, a write is followed by repeated reads of the written address. Each read keeps `mem_oe_n` low for `RD_CYC` cycles. The write completes when bit 7 (the MSB) of the read-back equals bit 7 of the written byte. The response never comes while the memory is still busy.
- R6: In ready/busy mode, a write completes when the synchronized `mem_rdy` input is 1 (1 = ready, 0 = busy). `mem_oe_n` stays high during the wait, and the response never comes while the memory is still busy.
- R7: If a write has not completed after `TIMEOUT_CYC` cycles, counted from the rise of `mem_we_n`, it ends at the next check with `rsp_valid` and `rsp_timeout` both 1. The next accepted request clears `rsp_timeout`.
- R8: A read drives `mem_ce_n` and `mem_oe_n` low for `RD_CYC` cycles, with `mem_dq_oe` at 0. `rsp_valid` comes in the cycle after the last strobe cycle, which is `RD_CYC + 1` cycles after the accepting edge. `rsp_rdata` holds the byte sampled in that last strobe cycle.
- R9: `rsp_valid` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = byte write, 0 = read |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Byte to write |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DW | Read data (for a write: last read-back byte) |
| rsp_timeout | output | 1 | Write ended without completion |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | AW | Memory address |
| mem_dq_out | output | DW | Data toward memory |
| mem_dq_oe | output | 1 | Enable for the host data driver |
| mem_dq_in | input | DW | Data from memory |
| mem_rdy | input | 1 | Open-drain ready/busy level, pulled up |

## Verification
Every strobe is a flop that is loaded on the same edge as the state. The first cycle of each phase therefore shows up on the first falling clock edge after the edge that entered it. The bench counts falling edges from the accepting edge. It expects the setup, pulse and hold widths in that order of counted cycles, and it expects the read response on falling edge `RD_CYC + 1`. Write responses depend on the memory model's busy time, so the bench checks them against bounds: at the response the model must no longer be busy, and a stuck write must not end before `TIMEOUT_CYC` cycles have passed. The ready level is sampled at the response falling edge and again one cycle later.

// File: rtl/eewp_pkg.sv
package eewp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_SETUP      = 3'd1,
    ST_STROBE     = 3'd2,
    ST_HOLD       = 3'd3,
    ST_POLL_READ  = 3'd4,
    ST_POLL_CHECK = 3'd5,
    ST_READ       = 3'd6,
    ST_DONE       = 3'd7
  } eewp_state_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic dq_oe;
  } eewp_bus_t;

  localparam eewp_bus_t BUS_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

  localparam int MODE_DATA_POLL = 0;
  localparam int MODE_RDY_BUSY  = 1;

endpackage

// File: rtl/eewp_sync.sv
module eewp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sr[0] <= 1'b1;
          else     sr[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sr[i] <= 1'b1;
          else     sr[i] <= sr[i-1];
        end
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/eewp_phase.sv
module eewp_phase #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nxt,
  output logic         last
);
  always_comb begin
    if (load)              cnt_nxt = load_val;
    else if (cnt != '0)    cnt_nxt = cnt - 1'b1;
    else                   cnt_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_nxt;
  end

  assign last = (cnt == '0);
endmodule

// File: rtl/eewp_wdog.sv
module eewp_wdog #(
  parameter int LIMIT = 20000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  assign expired = (cnt >= CW'(LIMIT));

  always_ff @(posedge clk) begin
    if (rst || clr)          cnt <= '0;
    else if (en && !expired) cnt <= cnt + 1'b1;
  end

  // R7
  wd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (expired && !clr) |=> expired);

  // R7
  wd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> !expired);
endmodule

// File: rtl/eewp_ctrl.sv
module eewp_ctrl
  import eewp_pkg::*;
#(
  parameter int AW          = 11,
  parameter int DW          = 8,
  parameter int SETUP_CYC   = 2,
  parameter int WE_CYC      = 10,
  parameter int HOLD_CYC    = 2,
  parameter int RD_CYC      = 16,
  parameter int POLL_GAP    = 4,
  parameter int TIMEOUT_CYC = 20000,
  parameter int POLL_MODE   = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_timeout,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in,
  input  logic          mem_rdy
);
  localparam int POLL_LEN = POLL_GAP + RD_CYC;
  localparam int PW       = $clog2(SETUP_CYC + WE_CYC + HOLD_CYC + POLL_LEN + 1);

  eewp_state_e   st, st_n;
  logic          ph_load, ph_last;
  logic [PW-1:0] ph_val, ph_cnt, ph_nxt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q, rd_q;
  logic          wr_q, to_q, ready_q, rsp_q;
  logic          rdy_s, wd_exp, wd_clr, wd_en, poll_ok, accept;
  eewp_bus_t     bus_n, bus_q;

  eewp_phase #(.W(PW)) u_phase (
    .clk(clk), .rst(rst), .load(ph_load), .load_val(ph_val),
    .cnt(ph_cnt), .cnt_nxt(ph_nxt), .last(ph_last)
  );

  eewp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(mem_rdy), .q(rdy_s)
  );

  assign wd_clr = (st == ST_IDLE);
  assign wd_en  = (st == ST_HOLD) || (st == ST_POLL_READ) || (st == ST_POLL_CHECK);

  eewp_wdog #(.LIMIT(TIMEOUT_CYC)) u_wdog (
    .clk(clk), .rst(rst), .clr(wd_clr), .en(wd_en), .expired(wd_exp)
  );

  assign accept  = req_valid && ready_q;
  assign poll_ok = (POLL_MODE == MODE_DATA_POLL) ? (rd_q[DW-1] == data_q[DW-1]) : rdy_s;

  always_comb begin
    st_n    = st;
    ph_load = 1'b0;
    ph_val  = '0;
    case (st)
      ST_IDLE: begin
        if (accept) begin
          ph_load = 1'b1;
          if (req_write) begin
            st_n   = ST_SETUP;
            ph_val = PW'(SETUP_CYC - 1);
          end else begin
            st_n   = ST_READ;
            ph_val = PW'(RD_CYC - 1);
          end
        end
      end
      ST_SETUP: if (ph_last) begin
        st_n = ST_STROBE; ph_load = 1'b1; ph_val = PW'(WE_CYC - 1);
      end
      ST_STROBE: if (ph_last) begin
        st_n = ST_HOLD; ph_load = 1'b1; ph_val = PW'(HOLD_CYC - 1);
      end
      ST_HOLD: if (ph_last) begin
        st_n = ST_POLL_READ; ph_load = 1'b1; ph_val = PW'(POLL_LEN - 1);
      end
      ST_POLL_READ: if (ph_last) begin
        st_n = ST_POLL_CHECK; ph_load = 1'b1;
      end
      ST_POLL_CHECK: begin
        ph_load = 1'b1;
        if (poll_ok || wd_exp) begin
          st_n = ST_DONE;
        end else begin
          st_n   = ST_POLL_READ;
          ph_val = PW'(POLL_LEN - 1);
        end
      end
      ST_READ: if (ph_last) begin
        st_n = ST_DONE; ph_load = 1'b1;
      end
      ST_DONE: st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  function automatic eewp_bus_t bus_for(eewp_state_e s, logic [PW-1:0] c);
    eewp_bus_t b;
    b = BUS_IDLE;
    case (s)
      ST_SETUP, ST_HOLD: begin
        b.ce_n = 1'b0; b.dq_oe = 1'b1;
      end
      ST_STROBE: begin
        b.ce_n = 1'b0; b.we_n = 1'b0; b.dq_oe = 1'b1;
      end
      ST_READ: begin
        b.ce_n = 1'b0; b.oe_n = 1'b0;
      end
      ST_POLL_READ: begin
        if (POLL_MODE == MODE_DATA_POLL && c < PW'(RD_CYC)) begin
          b.ce_n = 1'b0; b.oe_n = 1'b0;
        end
      end
      default: b = BUS_IDLE;
    endcase
    return b;
  endfunction

  assign bus_n = bus_for(st_n, ph_nxt);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      bus_q   <= BUS_IDLE;
      ready_q <= 1'b1;
      rsp_q   <= 1'b0;
      to_q    <= 1'b0;
      rd_q    <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      wr_q    <= 1'b0;
    end else begin
      st      <= st_n;
      bus_q   <= bus_n;
      ready_q <= (st_n == ST_IDLE);
      rsp_q   <= (st_n == ST_DONE);
      if (accept) begin
        addr_q <= req_addr;
        data_q <= req_wdata;
        wr_q   <= req_write;
        to_q   <= 1'b0;
      end else if (st == ST_POLL_CHECK && !poll_ok && wd_exp) begin
        to_q   <= 1'b1;
      end
      if ((st == ST_READ || st == ST_POLL_READ) && ph_last && !bus_q.oe_n)
        rd_q <= mem_dq_in;
    end
  end

  assign req_ready   = ready_q;
  assign rsp_valid   = rsp_q;
  assign rsp_rdata   = rd_q;
  assign rsp_timeout = to_q;
  assign mem_ce_n    = bus_q.ce_n;
  assign mem_oe_n    = bus_q.oe_n;
  assign mem_we_n    = bus_q.we_n;
  assign mem_dq_oe   = bus_q.dq_oe;
  assign mem_addr    = addr_q;
  assign mem_dq_out  = data_q;

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n));

  // R4
  bus_turn_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !mem_dq_oe);

  // R3
  we_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> ($stable(mem_addr) && $stable(mem_dq_out) && !mem_ce_n && mem_dq_oe));

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> (!rsp_valid && req_ready));

  // R7
  timeout_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_timeout) |-> wd_exp);

  generate
    if (POLL_MODE == MODE_RDY_BUSY) begin : g_rdy_chk
      // R6
      rdy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_POLL_READ || st == ST_POLL_CHECK) |-> mem_oe_n);
    end else begin : g_poll_chk
      // R5
      poll_done_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && wr_q && !rsp_timeout) |-> (rsp_rdata[DW-1] == mem_dq_out[DW-1]));
    end
  endgenerate
endmodule

// File: tb/sim_eewp_mem_model.sv
module sim_eewp_mem_model #(
  parameter int AW       = 11,
  parameter int DW       = 8,
  parameter int BUSY_CYC = 40
) (
  input  logic          clk,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          rdy,
  input  logic          stuck,
  output logic          busy
);
  logic [DW-1:0] mem [0:(1<<AW)-1];
  logic [DW-1:0] wval = '0;
  logic          we_d = 1'b1;
  int            bcnt = 0;

  initial begin
    busy = 1'b0;
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
  end

  always @(posedge clk) begin
    we_d <= we_n;
    if (we_n && !we_d && !ce_n) begin
      mem[addr] <= din;
      wval      <= din;
      busy      <= 1'b1;
      bcnt      <= BUSY_CYC;
    end else if (busy && !stuck) begin
      if (bcnt <= 1) busy <= 1'b0;
      bcnt <= bcnt - 1;
    end
  end

  assign dout = (!ce_n && !oe_n) ? (busy ? ~wval : mem[addr]) : '0;
  assign rdy  = !busy;
endmodule

// File: tb/sim_eewp_ctrl.sv
`timescale 1ns/1ps
module sim_eewp_ctrl;
  localparam int AW = 11, DW = 8;
  localparam int SETUP = 2, WEC = 3, HOLD = 2, RDC = 2, GAP = 4, TMO = 300, BUSY = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          req_valid [2];
  logic          req_ready [2];
  logic          req_write [2];
  logic [AW-1:0] req_addr  [2];
  logic [DW-1:0] req_wdata [2];
  logic          rsp_valid [2];
  logic [DW-1:0] rsp_rdata [2];
  logic          rsp_timeout [2];
  logic          mem_ce_n [2];
  logic          mem_oe_n [2];
  logic          mem_we_n [2];
  logic [AW-1:0] mem_addr [2];
  logic [DW-1:0] mem_dq_out [2];
  logic          mem_dq_oe [2];
  logic [DW-1:0] mem_dq_in [2];
  logic          mem_rdy [2];
  logic          stuck [2];
  logic          m_busy [2];

  eewp_ctrl #(.AW(AW), .DW(DW), .SETUP_CYC(SETUP), .WE_CYC(WEC), .HOLD_CYC(HOLD),
    .RD_CYC(RDC), .POLL_GAP(GAP), .TIMEOUT_CYC(TMO), .POLL_MODE(0), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid[0]), .req_ready(req_ready[0]),
    .req_write(req_write[0]), .req_addr(req_addr[0]), .req_wdata(req_wdata[0]),
    .rsp_valid(rsp_valid[0]), .rsp_rdata(rsp_rdata[0]), .rsp_timeout(rsp_timeout[0]),
    .mem_ce_n(mem_ce_n[0]), .mem_oe_n(mem_oe_n[0]), .mem_we_n(mem_we_n[0]),
    .mem_addr(mem_addr[0]), .mem_dq_out(mem_dq_out[0]), .mem_dq_oe(mem_dq_oe[0]),
    .mem_dq_in(mem_dq_in[0]), .mem_rdy(mem_rdy[0]));

  eewp_ctrl #(.AW(AW), .DW(DW), .SETUP_CYC(SETUP), .WE_CYC(WEC), .HOLD_CYC(HOLD),
    .RD_CYC(RDC), .POLL_GAP(GAP), .TIMEOUT_CYC(TMO), .POLL_MODE(1), .SYNC_STAGES(2)) u1 (
    .clk(clk), .rst(rst), .req_valid(req_valid[1]), .req_ready(req_ready[1]),
    .req_write(req_write[1]), .req_addr(req_addr[1]), .req_wdata(req_wdata[1]),
    .rsp_valid(rsp_valid[1]), .rsp_rdata(rsp_rdata[1]), .rsp_timeout(rsp_timeout[1]),
    .mem_ce_n(mem_ce_n[1]), .mem_oe_n(mem_oe_n[1]), .mem_we_n(mem_we_n[1]),
    .mem_addr(mem_addr[1]), .mem_dq_out(mem_dq_out[1]), .mem_dq_oe(mem_dq_oe[1]),
    .mem_dq_in(mem_dq_in[1]), .mem_rdy(mem_rdy[1]));

  for (genvar g = 0; g < 2; g++) begin : g_mem
    sim_eewp_mem_model #(.AW(AW), .DW(DW), .BUSY_CYC(BUSY)) u_mem (
      .clk(clk), .ce_n(mem_ce_n[g]), .oe_n(mem_oe_n[g]), .we_n(mem_we_n[g]),
      .addr(mem_addr[g]), .din(mem_dq_out[g]), .dout(mem_dq_in[g]), .rdy(mem_rdy[g]),
      .stuck(stuck[g]), .busy(m_busy[g]));
  end

  // {write, addr[10:0], data[7:0]}
  localparam logic [19:0] VEC [0:7] = '{
    {1'b1, 11'h000, 8'hA5}, {1'b1, 11'h7FF, 8'h3C}, {1'b1, 11'h123, 8'h80},
    {1'b0, 11'h000, 8'h00}, {1'b0, 11'h7FF, 8'h00}, {1'b1, 11'h123, 8'h7F},
    {1'b0, 11'h123, 8'h00}, {1'b0, 11'h456, 8'h00}
  };

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [DW-1:0] shadow [0:1][0:(1<<AW)-1];

  int lat, m_setup, m_we, m_hold, m_oe, m_clash, m_bad;
  logic [DW-1:0] r_data;
  logic r_to, r_rdy_at, r_rdy_after, r_busy_at, r_valid_after;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic txn(input int k, input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int n;
    bit seen_we;
    m_setup = 0; m_we = 0; m_hold = 0; m_oe = 0; m_clash = 0; m_bad = 0; seen_we = 0;
    @(negedge clk);
    chk("R2", "ready before request", int'(req_ready[k]), 1);
    req_valid[k] = 1'b1; req_write[k] = wr; req_addr[k] = a; req_wdata[k] = d;
    @(posedge clk);
    @(negedge clk);
    req_valid[k] = 1'b0;
    n = 1;
    while (!rsp_valid[k] && n < 5000) begin
      if (mem_dq_oe[k]) begin
        if (mem_addr[k] != a || mem_dq_out[k] != d || mem_ce_n[k]) m_bad++;
        if (!mem_we_n[k]) begin m_we++; seen_we = 1; end
        else if (seen_we) m_hold++;
        else m_setup++;
      end
      if (!mem_oe_n[k]) begin
        m_oe++;
        if (!mem_we_n[k] || mem_dq_oe[k] || mem_addr[k] != a) m_clash++;
      end
      @(negedge clk);
      n++;
    end
    lat = n; r_data = rsp_rdata[k]; r_to = rsp_timeout[k];
    r_rdy_at = req_ready[k]; r_busy_at = m_busy[k];
    @(negedge clk);
    r_rdy_after = req_ready[k]; r_valid_after = rsp_valid[k];
  endtask

  task automatic common_checks();
    chk("R2", "ready at response", int'(r_rdy_at), 0);
    chk("R2", "ready after response", int'(r_rdy_after), 1);
    chk("R9", "valid one cycle", int'(r_valid_after), 0);
    chk("R4", "strobe clash cycles", m_clash, 0);
  endtask

  task automatic write_checks(input int k);
    chk("R3", "setup cycles", m_setup, SETUP);
    chk("R3", "we low cycles", m_we, WEC);
    chk("R3", "hold cycles", m_hold, HOLD);
    chk("R3", "addr/data steady", m_bad, 0);
    chk("R7", "no timeout", int'(r_to), 0);
    if (k == 0) begin
      chk("R5", "memory idle at response", int'(r_busy_at), 0);
      chk("R5", "poll reads seen", int'(m_oe > 0), 1);
      chk("R5", "msb matches", int'(r_data[7]), int'(req_wdata[0][7]));
    end else begin
      chk("R6", "memory idle at response", int'(r_busy_at), 0);
      chk("R6", "no reads while waiting", m_oe, 0);
    end
    chk("R5", "latency bound", int'(lat <= SETUP + WEC + HOLD + BUSY + 2*(GAP+RDC+1) + 8), 1);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 2; k++) begin
      req_valid[k] = 0; req_write[k] = 0; req_addr[k] = '0; req_wdata[k] = '0; stuck[k] = 0;
      for (int i = 0; i < (1 << AW); i++) shadow[k][i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      chk("R1", "reset strobes", int'({mem_ce_n[k], mem_oe_n[k], mem_we_n[k], mem_dq_oe[k]}), 4'b1110);
      chk("R1", "reset ready/valid", int'({req_ready[k], rsp_valid[k]}), 2'b10);
    end
    rst = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 2; k++)
      chk("R1", "after reset strobes", int'({mem_ce_n[k], mem_oe_n[k], mem_we_n[k], mem_dq_oe[k], req_ready[k]}), 5'b11101);

    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < 8; i++) begin
        txn(k, VEC[i][19], VEC[i][18:8], VEC[i][7:0]);
        common_checks();
        if (VEC[i][19]) begin
          write_checks(k);
          shadow[k][VEC[i][18:8]] = VEC[i][7:0];
        end else begin
          chk("R8", "read data", int'(r_data), int'(shadow[k][VEC[i][18:8]]));
          chk("R8", "read latency", lat, RDC + 1);
          chk("R8", "read strobe cycles", m_oe, RDC);
          chk("R7", "no timeout on read", int'(r_to), 0);
        end
      end
    end

    for (int k = 0; k < 2; k++) begin
      stuck[k] = 1'b1;
      txn(k, 1'b1, 11'h055, 8'hC3);
      chk("R7", "timeout flagged", int'(r_to), 1);
      chk("R7", "not before limit", int'(lat >= SETUP + WEC + TMO), 1);
      chk("R7", "soon after limit", int'(lat <= SETUP + WEC + TMO + GAP + RDC + HOLD + 12), 1);
      common_checks();
      stuck[k] = 1'b0;
      repeat (BUSY + 5) @(negedge clk);
      txn(k, 1'b0, 11'h055, 8'h00);
      chk("R7", "timeout cleared by next request", int'(r_to), 0);
      chk("R8", "data after stuck write", int'(r_data), 8'hC3);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule